// File: doc/BRIEF.md
# Load-Use Hazard and Bypass Unit

This block holds the hazard detection and operand forwarding logic for a five-stage in-order integer pipeline. Each cycle it compares the destination of the instruction in execute with the source registers of the instruction in decode. When a load's result is needed one instruction too early, it holds fetch and decode for one cycle and turns the execute slot into a bubble. It also raises the decode flush when the path resolved in execute disagrees with the path that was fetched. Both flushes are withheld while the pipeline is frozen by a long stall.

On the operand side, the unit picks the value to forward from the memory stage according to what produced it. A load forwards its read data, because its ALU result is only the effective address. A jump-and-link forwards the incremented PC. Anything else forwards the ALU result. The forwarded value is also latched into a one-entry write-back slot, so the instruction after next can still take it from the bypass. Both execute operands pass through the forwarding path, which chooses between the memory stage, the write-back slot and the register file value.

Top module: `hzd_unit`

## Requirements
- R1: `fe_stall`, `de_stall` and `ex_flush` are all 1 in a cycle in which all of these hold: `ex_valid`=1, `ex_is_load`=1, `de_valid`=1, at least one decode source with its use flag set equals a nonzero `ex_rd`, no redirect is pending, and `stall_cause` is 0 (none). If `ex_is_load`, `ex_valid` or `de_valid` is 0, none of the three is raised.
- R2: Register 0 never causes a load-use stall, and it is never forwarded: a source equal to 0 always selects the register file (`fwd_sel` = 0).
- R3: A decode source whose use flag is 0 never causes a stall, even when its index matches.
- R4: `de_flush` equals `ex_valid` AND NOT `ex_spec_hit`, except while a freezing stall cause (R6) is present.
- R5: When a load-use hazard and a decode flush occur in the same cycle, the flush wins: `de_flush`=1 and `fe_stall`=`de_stall`=`ex_flush`=0.
- R6: `stall_cause` codes 1 (fence), 2 (fetch miss), 3 (data miss) and 5 (multiply/divide) freeze the pipeline. Under these codes `de_flush` and `ex_flush` are 0, while a load-use hazard still raises `fe_stall`/`de_stall`. Codes 0 (none) and 4 (load-use) mask nothing.
- R7: `mem_bypass_data` follows `mem_kind`: 1 (load) gives `mem_read_data`, 2 (jump-and-link) gives `mem_pc_incr`, and 0 or 3 gives `mem_alu_result`.
- R8: If `mem_valid`=1, `mem_rd` is nonzero and `mem_rd` equals an execute source, that operand's select is 1 (memory) and its value is `mem_bypass_data`.
- R9: When the memory stage and the write-back slot both match the same source, the memory stage is forwarded.
- R10: At each clock edge with a non-freezing cause, the write-back slot takes `mem_valid`, `mem_rd` and `mem_bypass_data`. In the next cycle a matching source with no memory-stage match gets select 2 (write-back) and the latched value.
- R11: At a clock edge with a freezing cause, the write-back slot keeps its contents.
- R12: After synchronous reset the write-back slot is empty, so with no memory-stage match both operands select 0 and pass `ex_rf_a`/`ex_rf_b`.
- R13: A load-use stall lasts one cycle. Once the load has moved on and the execute slot holds the bubble, no stall is raised, and the consumer then receives the load data through the bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_rd | input | 5 | Execute destination register |
| ex_spec_hit | input | 1 | Resolved path in execute matches the fetched path |
| ex_rs1 | input | 5 | Execute source register A |
| ex_rs2 | input | 5 | Execute source register B |
| ex_rf_a | input | 32 | Register file value for source A |
| ex_rf_b | input | 32 | Register file value for source B |
| de_valid | input | 1 | Decode stage holds an instruction |
| de_rs1 | input | 5 | Decode source register A |
| de_rs2 | input | 5 | Decode source register B |
| de_use_rs1 | input | 1 | Decode instruction reads source A |
| de_use_rs2 | input | 1 | Decode instruction reads source B |
| mem_valid | input | 1 | Memory stage holds a register-writing instruction |
| mem_kind | input | 2 | Producer type: 0 ALU, 1 load, 2 jump-and-link |
| mem_rd | input | 5 | Memory stage destination register |
| mem_alu_result | input | 32 | ALU result in memory stage |
| mem_read_data | input | 32 | Load read data in memory stage |
| mem_pc_incr | input | 32 | Incremented PC in memory stage |
| stall_cause | input | 3 | Active stall cause: 0 none, 1 fence, 2 fetch miss, 3 data miss, 4 load-use, 5 multiply/divide |
| fe_stall | output | 1 | Hold fetch |
| de_stall | output | 1 | Hold decode |
| de_flush | output | 1 | Squash decode |
| ex_flush | output | 1 | Insert bubble into execute |
| fwd_sel_a | output | 2 | Source A select: 0 register file, 1 memory, 2 write-back |
| fwd_sel_b | output | 2 | Source B select, same coding |
| op_a | output | 32 | Forwarded operand A |
| op_b | output | 32 | Forwarded operand B |
| mem_bypass_data | output | 32 | Value forwarded from the memory stage |

## Verification
The properties assume that the stall cause takes only the six defined codes and that `mem_kind` is stable within a cycle. They also assume that valid flags and register indices are driven to known values from reset onward. The bench drives every input at the falling edge from that defined set and never leaves an input undriven. For the sequence checks it moves instructions between stages the way the surrounding pipeline would, holding decode in the cycle after a stall and placing a bubble in execute.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int XLEN_DEF = 32;
    localparam int RAW_DEF  = 5;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_FENCE   = 3'd1,
        CAUSE_IFETCH  = 3'd2,
        CAUSE_DATA    = 3'd3,
        CAUSE_LOADUSE = 3'd4,
        CAUSE_MULDIV  = 3'd5
    } cause_e;

    typedef enum logic [1:0] {
        PROD_ALU  = 2'd0,
        PROD_LOAD = 2'd1,
        PROD_LINK = 2'd2
    } prod_e;

    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_MEM = 2'd1,
        SRC_WB  = 2'd2
    } fsel_e;

    // Causes that freeze the pipeline and therefore mask flushes.
    function automatic logic cause_freezes(logic [2:0] c);
        return (c == CAUSE_FENCE) || (c == CAUSE_IFETCH) ||
               (c == CAUSE_DATA)  || (c == CAUSE_MULDIV);
    endfunction

endpackage

// File: rtl/hzd_loaduse.sv
module hzd_loaduse #(
    parameter int RAW = hzd_pkg::RAW_DEF
) (
    input  logic           ex_valid,
    input  logic           ex_is_load,
    input  logic [RAW-1:0] ex_rd,
    input  logic           de_valid,
    input  logic [RAW-1:0] de_rs1,
    input  logic [RAW-1:0] de_rs2,
    input  logic           de_use_rs1,
    input  logic           de_use_rs2,
    output logic           lu_raw
);
    logic producer_ok;
    logic hit_a;
    logic hit_b;

    always_comb begin
        producer_ok = ex_valid && ex_is_load && (ex_rd != '0) && de_valid;
        hit_a       = de_use_rs1 && (de_rs1 == ex_rd);
        hit_b       = de_use_rs2 && (de_rs2 == ex_rd);
        lu_raw      = producer_ok && (hit_a || hit_b);
    end
endmodule

// File: rtl/hzd_flush_ctl.sv
module hzd_flush_ctl (
    input  logic       lu_raw,
    input  logic       ex_valid,
    input  logic       ex_spec_hit,
    input  logic [2:0] stall_cause,
    output logic       fe_stall,
    output logic       de_stall,
    output logic       de_flush,
    output logic       ex_flush
);
    import hzd_pkg::*;

    logic freeze;
    logic redirect;
    logic hold;

    always_comb begin
        freeze   = cause_freezes(stall_cause);
        redirect = ex_valid && !ex_spec_hit;
        de_flush = redirect && !freeze;
        // A squashed consumer needs no bubble: the flush wins.
        hold     = lu_raw && !de_flush;
        fe_stall = hold;
        de_stall = hold;
        ex_flush = hold && !freeze;
    end
endmodule

// File: rtl/hzd_fwd_mux.sv
module hzd_fwd_mux #(
    parameter int XLEN = hzd_pkg::XLEN_DEF,
    parameter int RAW  = hzd_pkg::RAW_DEF
) (
    input  logic [RAW-1:0]  src,
    input  logic [XLEN-1:0] rf_val,
    input  logic            mem_valid,
    input  logic [RAW-1:0]  mem_rd,
    input  logic [XLEN-1:0] mem_data,
    input  logic            wb_valid,
    input  logic [RAW-1:0]  wb_rd,
    input  logic [XLEN-1:0] wb_data,
    output logic [1:0]      sel,
    output logic [XLEN-1:0] val
);
    import hzd_pkg::*;

    logic  mem_hit;
    logic  wb_hit;
    fsel_e choice;

    always_comb begin
        mem_hit = mem_valid && (mem_rd != '0) && (mem_rd == src);
        wb_hit  = wb_valid  && (wb_rd  != '0) && (wb_rd  == src);
        if (mem_hit)     choice = SRC_MEM;
        else if (wb_hit) choice = SRC_WB;
        else             choice = SRC_RF;
        unique case (choice)
            SRC_MEM: val = mem_data;
            SRC_WB:  val = wb_data;
            default: val = rf_val;
        endcase
        sel = choice;
    end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit #(
    parameter int XLEN = hzd_pkg::XLEN_DEF,
    parameter int RAW  = hzd_pkg::RAW_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ex_valid,
    input  logic            ex_is_load,
    input  logic [RAW-1:0]  ex_rd,
    input  logic            ex_spec_hit,
    input  logic [RAW-1:0]  ex_rs1,
    input  logic [RAW-1:0]  ex_rs2,
    input  logic [XLEN-1:0] ex_rf_a,
    input  logic [XLEN-1:0] ex_rf_b,
    input  logic            de_valid,
    input  logic [RAW-1:0]  de_rs1,
    input  logic [RAW-1:0]  de_rs2,
    input  logic            de_use_rs1,
    input  logic            de_use_rs2,
    input  logic            mem_valid,
    input  logic [1:0]      mem_kind,
    input  logic [RAW-1:0]  mem_rd,
    input  logic [XLEN-1:0] mem_alu_result,
    input  logic [XLEN-1:0] mem_read_data,
    input  logic [XLEN-1:0] mem_pc_incr,
    input  logic [2:0]      stall_cause,
    output logic            fe_stall,
    output logic            de_stall,
    output logic            de_flush,
    output logic            ex_flush,
    output logic [1:0]      fwd_sel_a,
    output logic [1:0]      fwd_sel_b,
    output logic [XLEN-1:0] op_a,
    output logic [XLEN-1:0] op_b,
    output logic [XLEN-1:0] mem_bypass_data
);
    import hzd_pkg::*;

    localparam int NSRC = 2;

    logic            lu_raw;
    logic            wb_valid_q;
    logic [RAW-1:0]  wb_rd_q;
    logic [XLEN-1:0] wb_data_q;
    logic            advance;

    logic [RAW-1:0]  src_idx [NSRC];
    logic [XLEN-1:0] src_rf  [NSRC];
    logic [1:0]      src_sel [NSRC];
    logic [XLEN-1:0] src_val [NSRC];

    hzd_loaduse #(.RAW(RAW)) u_lu (
        .ex_valid   (ex_valid),
        .ex_is_load (ex_is_load),
        .ex_rd      (ex_rd),
        .de_valid   (de_valid),
        .de_rs1     (de_rs1),
        .de_rs2     (de_rs2),
        .de_use_rs1 (de_use_rs1),
        .de_use_rs2 (de_use_rs2),
        .lu_raw     (lu_raw)
    );

    hzd_flush_ctl u_fl (
        .lu_raw      (lu_raw),
        .ex_valid    (ex_valid),
        .ex_spec_hit (ex_spec_hit),
        .stall_cause (stall_cause),
        .fe_stall    (fe_stall),
        .de_stall    (de_stall),
        .de_flush    (de_flush),
        .ex_flush    (ex_flush)
    );

    // Producer-dependent memory-stage value: a load's ALU result is its address.
    always_comb begin
        unique case (mem_kind)
            PROD_LOAD: mem_bypass_data = mem_read_data;
            PROD_LINK: mem_bypass_data = mem_pc_incr;
            default:   mem_bypass_data = mem_alu_result;
        endcase
    end

    assign advance = !cause_freezes(stall_cause);

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid_q <= 1'b0;
            wb_rd_q    <= '0;
            wb_data_q  <= '0;
        end else if (advance) begin
            wb_valid_q <= mem_valid;
            wb_rd_q    <= mem_rd;
            wb_data_q  <= mem_bypass_data;
        end
    end

    always_comb begin
        src_idx[0] = ex_rs1;
        src_idx[1] = ex_rs2;
        src_rf[0]  = ex_rf_a;
        src_rf[1]  = ex_rf_b;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hzd_fwd_mux #(.XLEN(XLEN), .RAW(RAW)) u_mux (
            .src       (src_idx[g]),
            .rf_val    (src_rf[g]),
            .mem_valid (mem_valid),
            .mem_rd    (mem_rd),
            .mem_data  (mem_bypass_data),
            .wb_valid  (wb_valid_q),
            .wb_rd     (wb_rd_q),
            .wb_data   (wb_data_q),
            .sel       (src_sel[g]),
            .val       (src_val[g])
        );
    end

    assign fwd_sel_a = src_sel[0];
    assign fwd_sel_b = src_sel[1];
    assign op_a      = src_val[0];
    assign op_b      = src_val[1];

endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
    parameter int XLEN = hzd_pkg::XLEN_DEF,
    parameter int RAW  = hzd_pkg::RAW_DEF
) (
    input logic            clk,
    input logic            rst,
    input logic            ex_valid,
    input logic            ex_spec_hit,
    input logic [RAW-1:0]  ex_rs1,
    input logic            mem_valid,
    input logic [1:0]      mem_kind,
    input logic [RAW-1:0]  mem_rd,
    input logic [XLEN-1:0] mem_read_data,
    input logic [2:0]      stall_cause,
    input logic            fe_stall,
    input logic            de_flush,
    input logic            ex_flush,
    input logic [1:0]      fwd_sel_a,
    input logic [XLEN-1:0] op_a,
    input logic            wb_valid,
    input logic [XLEN-1:0] wb_data
);
    logic frz;
    assign frz = (stall_cause == 3'd1) || (stall_cause == 3'd2) ||
                 (stall_cause == 3'd3) || (stall_cause == 3'd5);

    // R1: an execute bubble only accompanies a held front end
    a_r1_bubble_with_hold: assert property (@(posedge clk) disable iff (rst)
        ex_flush |-> fe_stall);

    // R5: a decode flush never coexists with a hold
    a_r5_flush_wins: assert property (@(posedge clk) disable iff (rst)
        de_flush |-> !fe_stall);

    // R6: freezing causes mask both flushes
    a_r6_mask: assert property (@(posedge clk) disable iff (rst)
        frz |-> (!de_flush && !ex_flush));

    // R4: a missed speculation flushes decode when not frozen
    a_r4_redirect: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && !ex_spec_hit && !frz) |-> de_flush);

    // R2: register 0 is never taken from the memory stage
    a_r2_no_zero_fwd: assert property (@(posedge clk) disable iff (rst)
        (fwd_sel_a == 2'd1) |-> (mem_rd != '0));

    // R9: memory-stage match always wins
    a_r9_mem_first: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_rd != '0 && mem_rd == ex_rs1) |-> (fwd_sel_a == 2'd1));

    // R7: a load in memory forwards its read data
    a_r7_load_data: assert property (@(posedge clk) disable iff (rst)
        (fwd_sel_a == 2'd1 && mem_kind == 2'd1) |-> (op_a == mem_read_data));

    // R11: a freezing cause holds the write-back slot
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        frz |=> $stable(wb_data));

    // R10: a valid memory producer fills the slot when advancing
    a_r10_fill: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !frz) |=> wb_valid);
endmodule

bind hzd_unit hzd_unit_chk #(.XLEN(XLEN), .RAW(RAW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ex_valid      (ex_valid),
    .ex_spec_hit   (ex_spec_hit),
    .ex_rs1        (ex_rs1),
    .mem_valid     (mem_valid),
    .mem_kind      (mem_kind),
    .mem_rd        (mem_rd),
    .mem_read_data (mem_read_data),
    .stall_cause   (stall_cause),
    .fe_stall      (fe_stall),
    .de_flush      (de_flush),
    .ex_flush      (ex_flush),
    .fwd_sel_a     (fwd_sel_a),
    .op_a          (op_a),
    .wb_valid      (wb_valid_q),
    .wb_data       (wb_data_q)
);

// File: tb/tb_hzd_unit.sv
`timescale 1ns/1ps
module tb_hzd_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        ex_valid, ex_is_load, ex_spec_hit;
    logic [4:0]  ex_rd, ex_rs1, ex_rs2;
    logic [31:0] ex_rf_a, ex_rf_b;
    logic        de_valid, de_use_rs1, de_use_rs2;
    logic [4:0]  de_rs1, de_rs2;
    logic        mem_valid;
    logic [1:0]  mem_kind;
    logic [4:0]  mem_rd;
    logic [31:0] mem_alu_result, mem_read_data, mem_pc_incr;
    logic [2:0]  stall_cause;
    logic        fe_stall, de_stall, de_flush, ex_flush;
    logic [1:0]  fwd_sel_a, fwd_sel_b;
    logic [31:0] op_a, op_b, mem_bypass_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    hzd_unit dut (.*);

    typedef struct packed {
        logic [3:0] req;
        logic       exv;
        logic       ld;
        logic [4:0] exrd;
        logic       dev;
        logic [4:0] r1;
        logic [4:0] r2;
        logic       u1;
        logic       u2;
        logic       hit;
        logic [2:0] cause;
        logic       e_stall;
        logic       e_def;
        logic       e_exf;
    } hv_t;

    localparam int NV = 14;
    localparam hv_t TBL [NV] = '{
        '{4'd1, 1'b1,1'b1,5'd7, 1'b1,5'd7,5'd3, 1'b1,1'b1,1'b1,3'd0, 1'b1,1'b0,1'b1}, // R1 via rs1
        '{4'd1, 1'b1,1'b1,5'd9, 1'b1,5'd2,5'd9, 1'b1,1'b1,1'b1,3'd0, 1'b1,1'b0,1'b1}, // R1 via rs2
        '{4'd2, 1'b1,1'b1,5'd0, 1'b1,5'd0,5'd0, 1'b1,1'b1,1'b1,3'd0, 1'b0,1'b0,1'b0}, // R2 x0
        '{4'd3, 1'b1,1'b1,5'd9, 1'b1,5'd2,5'd9, 1'b1,1'b0,1'b1,3'd0, 1'b0,1'b0,1'b0}, // R3 unused rs2
        '{4'd1, 1'b1,1'b0,5'd7, 1'b1,5'd7,5'd7, 1'b1,1'b1,1'b1,3'd0, 1'b0,1'b0,1'b0}, // R1 non-load
        '{4'd4, 1'b1,1'b0,5'd3, 1'b1,5'd4,5'd5, 1'b1,1'b1,1'b0,3'd0, 1'b0,1'b1,1'b0}, // R4 redirect
        '{4'd5, 1'b1,1'b1,5'd7, 1'b1,5'd7,5'd0, 1'b1,1'b1,1'b0,3'd0, 1'b0,1'b1,1'b0}, // R5 flush wins
        '{4'd6, 1'b1,1'b1,5'd7, 1'b1,5'd7,5'd0, 1'b1,1'b1,1'b1,3'd3, 1'b1,1'b0,1'b0}, // R6 data miss
        '{4'd6, 1'b1,1'b0,5'd3, 1'b1,5'd1,5'd1, 1'b1,1'b1,1'b0,3'd5, 1'b0,1'b0,1'b0}, // R6 muldiv
        '{4'd6, 1'b1,1'b0,5'd3, 1'b1,5'd1,5'd1, 1'b1,1'b1,1'b0,3'd4, 1'b0,1'b1,1'b0}, // R6 code 4 no mask
        '{4'd6, 1'b1,1'b1,5'd7, 1'b1,5'd7,5'd0, 1'b1,1'b1,1'b0,3'd1, 1'b1,1'b0,1'b0}, // R6 fence
        '{4'd1, 1'b1,1'b1,5'd7, 1'b0,5'd7,5'd7, 1'b1,1'b1,1'b1,3'd0, 1'b0,1'b0,1'b0}, // R1 decode empty
        '{4'd4, 1'b0,1'b1,5'd7, 1'b1,5'd7,5'd7, 1'b1,1'b1,1'b0,3'd0, 1'b0,1'b0,1'b0}, // R4 execute empty
        '{4'd6, 1'b1,1'b1,5'd7, 1'b1,5'd7,5'd7, 1'b1,1'b1,1'b1,3'd2, 1'b1,1'b0,1'b0}  // R6 fetch miss
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ex_valid = 0; ex_is_load = 0; ex_rd = 0; ex_spec_hit = 1;
        ex_rs1 = 0; ex_rs2 = 0; ex_rf_a = 32'h1111_0000; ex_rf_b = 32'h2222_0000;
        de_valid = 0; de_rs1 = 0; de_rs2 = 0; de_use_rs1 = 0; de_use_rs2 = 0;
        mem_valid = 0; mem_kind = 0; mem_rd = 0;
        mem_alu_result = 32'hA0A0_0001; mem_read_data = 32'hB0B0_0002; mem_pc_incr = 32'hC0C0_0003;
        stall_cause = 0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R12: after reset nothing is forwarded
        ex_rs1 = 5'd6; ex_rs2 = 5'd8;
        #1;
        chk("R12 sel_a", {30'd0, fwd_sel_a}, 32'd0);
        chk("R12 op_b", op_b, ex_rf_b);
        chk("R12 stall", {31'd0, fe_stall}, 32'd0);

        // Control table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle_inputs();
            ex_valid = TBL[i].exv; ex_is_load = TBL[i].ld; ex_rd = TBL[i].exrd;
            de_valid = TBL[i].dev; de_rs1 = TBL[i].r1; de_rs2 = TBL[i].r2;
            de_use_rs1 = TBL[i].u1; de_use_rs2 = TBL[i].u2;
            ex_spec_hit = TBL[i].hit; stall_cause = TBL[i].cause;
            #1;
            chk($sformatf("R%0d row%0d fe_stall", TBL[i].req, i), {31'd0, fe_stall}, {31'd0, TBL[i].e_stall});
            chk($sformatf("R%0d row%0d de_stall", TBL[i].req, i), {31'd0, de_stall}, {31'd0, TBL[i].e_stall});
            chk($sformatf("R%0d row%0d de_flush", TBL[i].req, i), {31'd0, de_flush}, {31'd0, TBL[i].e_def});
            chk($sformatf("R%0d row%0d ex_flush", TBL[i].req, i), {31'd0, ex_flush}, {31'd0, TBL[i].e_exf});
        end

        // R7 / R8: producer-dependent memory bypass
        for (int k = 0; k < 4; k++) begin
            logic [31:0] exp;
            @(negedge clk);
            idle_inputs();
            mem_valid = 1; mem_rd = 5'd5; mem_kind = k[1:0]; ex_rs1 = 5'd5;
            exp = (k == 1) ? mem_read_data : (k == 2) ? mem_pc_incr : mem_alu_result;
            #1;
            chk($sformatf("R7 kind%0d bypass", k), mem_bypass_data, exp);
            chk($sformatf("R8 kind%0d op_a", k), op_a, exp);
            chk("R8 sel_a", {30'd0, fwd_sel_a}, 32'd1);
        end

        // R2: register 0 never forwarded
        @(negedge clk);
        idle_inputs();
        mem_valid = 1; mem_rd = 5'd0; ex_rs1 = 5'd0;
        #1;
        chk("R2 sel_a x0", {30'd0, fwd_sel_a}, 32'd0);
        chk("R2 op_a x0", op_a, ex_rf_a);

        // R10: capture into write-back slot
        @(negedge clk);
        idle_inputs();
        mem_valid = 1; mem_rd = 5'd6; mem_kind = 2'd1; mem_read_data = 32'hD1D1_0006;
        @(negedge clk);
        idle_inputs();
        ex_rs2 = 5'd6;
        #1;
        chk("R10 sel_b", {30'd0, fwd_sel_b}, 32'd2);
        chk("R10 op_b", op_b, 32'hD1D1_0006);

        // R9: memory stage beats write-back on the same register
        mem_valid = 1; mem_rd = 5'd6; mem_kind = 2'd0; mem_alu_result = 32'hE2E2_0006;
        #1;
        chk("R9 sel_b", {30'd0, fwd_sel_b}, 32'd1);
        chk("R9 op_b", op_b, 32'hE2E2_0006);

        // R11: freezing cause holds the slot
        stall_cause = 3'd3; mem_rd = 5'd8;
        @(negedge clk);
        idle_inputs();
        ex_rs1 = 5'd8; ex_rs2 = 5'd6;
        #1;
        chk("R11 sel_b held", {30'd0, fwd_sel_b}, 32'd2);
        chk("R11 op_b held", op_b, 32'hD1D1_0006);
        chk("R11 sel_a not taken", {30'd0, fwd_sel_a}, 32'd0);

        // R13: one-cycle stall then load data reaches consumer
        @(negedge clk);
        idle_inputs();
        ex_valid = 1; ex_is_load = 1; ex_rd = 5'd10;
        de_valid = 1; de_rs1 = 5'd10; de_use_rs1 = 1;
        #1;
        chk("R13 stall cycle", {31'd0, fe_stall}, 32'd1);
        @(negedge clk);
        idle_inputs();
        de_valid = 1; de_rs1 = 5'd10; de_use_rs1 = 1;
        mem_valid = 1; mem_rd = 5'd10; mem_kind = 2'd1; mem_read_data = 32'hF00D_000A;
        #1;
        chk("R13 no second stall", {31'd0, fe_stall}, 32'd0);
        chk("R13 no second bubble", {31'd0, ex_flush}, 32'd0);
        @(negedge clk);
        idle_inputs();
        ex_valid = 1; ex_rs1 = 5'd10;
        #1;
        chk("R13 consumer sel", {30'd0, fwd_sel_a}, 32'd2);
        chk("R13 consumer data", op_a, 32'hF00D_000A);

        // R12: reset empties the slot again
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        #1;
        chk("R12 slot cleared", {30'd0, fwd_sel_a}, 32'd0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule